// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive by producing refresh work on a fixed interval and playing out the strobe sequence for each refresh itself. Before it touches the memory pins it asks the memory controller for the bus with `bus_req_o` and waits for `bus_gnt_i`. It keeps the request up until the sequence, including its precharge, is over. Refreshes that fall due while the bus is held elsewhere are counted, up to a fixed limit, and are played out back to back once the bus is granted.

Three styles of refresh are chosen with `mode_i`. The first is CAS-before-RAS, where the memory's own row counter picks the row. The second is RAS-only, where the block drives the row from an internal 11-bit counter. The third is a burst style. It uses CAS-before-RAS for periodic work, and it also refreshes every row back to back just before the memory goes into self refresh and again just after it comes out.

Self refresh is entered on a `sr_enter_i` pulse and left on a `sr_exit_i` pulse. All durations are counted in clock cycles. With the default 5 ns clock they are: 3200 cycles between refreshes (2048 rows in 32.8 ms), 12 cycles of RAS low, 8 cycles of precharge, more than 100 us of self-refresh hold, and 22 cycles of recovery.

The controller is a state machine with these states:
- IDLE: no work.
- WAIT_GNT: request raised.
- CBR_CAS: CAS low alone for one cycle.
- CBR_RAS: both strobes low.
- ROR_ADDR: row driven with both strobes high.
- ROR_RAS: RAS low with CAS high.
- PRECHG: both strobes high.
- SR_CAS: CAS low alone.
- SR_HOLD: both strobes low.
- SR_RECOVER: both strobes high.

Its transitions are:
- IDLE to WAIT_GNT, on an owed refresh or a pending self-refresh entry.
- WAIT_GNT to SR_CAS (entry, non-burst modes), to CBR_CAS (entry in burst mode, or a periodic refresh in CAS-before-RAS or burst mode) or to ROR_ADDR (a periodic refresh in RAS-only mode).
- CBR_CAS to CBR_RAS.
- ROR_ADDR to ROR_RAS.
- CBR_RAS and ROR_RAS to PRECHG.
- PRECHG to CBR_CAS (burst not finished), to SR_CAS (entry burst finished) or to IDLE.
- SR_CAS to SR_HOLD.
- SR_HOLD to SR_RECOVER, on exit once the minimum hold has passed.
- SR_RECOVER to CBR_CAS (burst mode) or to IDLE.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is active and right after it, `ras_n_o` and `cas_n_o` are 1, and `bus_req_o`, `busy_o`, `addr_oe_o` and `overflow_o` are 0.
- R2: One refresh falls due every INTERVAL_CYC cycles, the first INTERVAL_CYC cycles after reset. `bus_req_o` rises within 3 cycles of it falling due. Neither strobe goes low unless `bus_req_o` and `bus_gnt_i` are both high. `busy_o` is high while work is owed or under way.
- R3: When `mode_i` is 0 (or the unused code 3), a refresh is CAS-before-RAS. CAS falls one cycle before RAS, both stay low for RAS_CYC cycles, then both rise together, and `addr_oe_o` stays 0.
- R4: When `mode_i` is 1, a refresh is RAS-only. `addr_oe_o` rises one cycle before RAS falls, `addr_o` holds the row while RAS is low for RAS_CYC cycles, and CAS stays high throughout.
- R5: After every refresh, both strobes stay high for at least PRE_CYC cycles (PRE_CYC of at least 2) before either falls again.
- R6: The row counter starts at 0. It advances by one after each RAS-only refresh, wraps from 2^ROW_W-1 to 0, and does not change otherwise.
- R7: Up to MAX_OWED refreshes can be owed at once. A refresh falling due while MAX_OWED are already owed sets `overflow_o`, which stays set until reset.
- R8: After a `sr_enter_i` pulse and a grant, CAS falls one cycle before RAS and both stay low. They stay low for at least SR_MIN_CYC cycles, and until a `sr_exit_i` pulse arrives. An exit pulse that comes before the minimum is kept and acted on when the minimum ends.
- R9: On exit, both strobes rise together and stay high for at least SR_PRE_CYC cycles. A `sr_exit_i` pulse outside self refresh has no effect on the strobes.
- R10: When `mode_i` is 2, entry to self refresh is preceded by 2^ROW_W back-to-back CAS-before-RAS refreshes, and exit is followed by another 2^ROW_W. The bus request stays raised from the first of these to the last.
- R11: Self refresh, and the completion of a full burst, clear the owed count and restart the interval. No request follows within INTERVAL_CYC/2 cycles afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Refresh style: 0 CAS-before-RAS, 1 RAS-only, 2 burst, 3 as 0 |
| sr_enter_i | input | 1 | One-cycle request to enter self refresh |
| sr_exit_i | input | 1 | One-cycle request to leave self refresh |
| bus_gnt_i | input | 1 | Memory bus granted by controller |
| bus_req_o | output | 1 | Memory bus wanted |
| busy_o | output | 1 | Work owed or sequence running |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ROW_W | Row for RAS-only refresh |
| addr_oe_o | output | 1 | Row address is being driven |
| overflow_o | output | 1 | Owed-refresh count overflowed (sticky) |

## Verification
The bench runs 2050 RAS-only refreshes so that the row counter passes its wrap. A counter that stopped at the top, or that also stepped on CAS-before-RAS refreshes, would put a wrong row on the pins. The bench withholds the grant for more than MAX_OWED intervals. A saturation that was off by one would raise the overflow flag too early or never. It sends an exit pulse well before the minimum self-refresh hold. A design that dropped that pulse would hang in self refresh, and one that acted on it at once would cut the hold short. After a burst and after self refresh, it checks that no request comes straight away. A design that kept the stale owed count would flood the bus with needless refreshes.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        MODE_CBR      = 2'd0,
        MODE_RAS_ONLY = 2'd1,
        MODE_BURST    = 2'd2,
        MODE_RSVD     = 2'd3
    } rfsh_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_ROR_ADDR,
        ST_ROR_RAS,
        ST_PRECHG,
        ST_SR_CAS,
        ST_SR_HOLD,
        ST_SR_RECOVER
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);

    // R2: ticks are at least INTERVAL_CYC apart (at least two cycles)
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rfsh_owed_ctr.sv
`timescale 1ns/1ps
module rfsh_owed_ctr #(
    parameter int MAX_OWED = 8,
    localparam int CW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          served,
    input  logic          clr,
    output logic [CW-1:0] owed,
    output logic          overflow
);
    localparam logic [CW-1:0] MAXV = CW'(MAX_OWED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed     <= '0;
            overflow <= 1'b0;
        end else if (clr) begin
            owed <= '0;
        end else if (tick && !served) begin
            if (owed == MAXV) overflow <= 1'b1;
            else              owed     <= owed + 1'b1;
        end else if (!tick && served && owed != '0) begin
            owed <= owed - 1'b1;
        end
    end

    p_owed_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= MAXV);
    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/rfsh_row_ctr.sv
`timescale 1ns/1ps
module rfsh_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end

    p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> row == $past(row) + 1'b1);
    p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row));
endmodule

// File: rtl/dram_rfsh_sched.sv
`timescale 1ns/1ps
module dram_rfsh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int INTERVAL_CYC = 3200,
    parameter int RAS_CYC      = 12,
    parameter int PRE_CYC      = 8,
    parameter int SR_MIN_CYC   = 20001,
    parameter int SR_PRE_CYC   = 22,
    parameter int MAX_OWED     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             sr_enter_i,
    input  logic             sr_exit_i,
    input  logic             bus_gnt_i,
    output logic             bus_req_o,
    output logic             busy_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             addr_oe_o,
    output logic             overflow_o
);
    localparam int M1   = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
    localparam int M2   = (SR_MIN_CYC > SR_PRE_CYC) ? SR_MIN_CYC : SR_PRE_CYC;
    localparam int MAXD = (M1 > M2) ? M1 : M2;
    localparam int DW   = $clog2(MAXD + 1);
    localparam int BW   = ROW_W + 1;
    localparam int OW   = $clog2(MAX_OWED + 1);
    localparam logic [BW-1:0] BURST_LEN = BW'(1 << ROW_W);

    rfsh_state_e   st, nxt;
    rfsh_mode_e    mode;
    logic [DW-1:0] dly, dly_ld;
    logic [BW-1:0] burst_left, burst_nxt;
    logic          enter_pend, exit_seen;
    logic          tick, served, burst_end, in_sr, clr_work, row_inc, dly_done;
    logic [OW-1:0] owed;

    assign mode      = rfsh_mode_e'(mode_i);
    assign dly_done  = (dly == '0);
    assign in_sr     = (st == ST_SR_CAS) || (st == ST_SR_HOLD) || (st == ST_SR_RECOVER);
    assign served    = (st == ST_PRECHG) && dly_done && (burst_left == '0);
    assign burst_end = (st == ST_PRECHG) && dly_done && (burst_left == BW'(1));
    assign clr_work  = in_sr || burst_end;
    assign row_inc   = (st == ST_ROR_RAS) && dly_done;

    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_work), .tick(tick));

    rfsh_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .served(served),
        .clr(clr_work), .owed(owed), .overflow(overflow_o));

    rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .inc(row_inc), .row(addr_o));

    // next state
    always_comb begin
        nxt       = st;
        burst_nxt = burst_left;
        unique case (st)
            ST_IDLE:
                if (enter_pend || owed != '0) nxt = ST_WAIT_GNT;
            ST_WAIT_GNT:
                if (bus_gnt_i) begin
                    if (enter_pend && mode == MODE_BURST) begin
                        burst_nxt = BURST_LEN;
                        nxt       = ST_CBR_CAS;
                    end else if (enter_pend)        nxt = ST_SR_CAS;
                    else if (mode == MODE_RAS_ONLY) nxt = ST_ROR_ADDR;
                    else                            nxt = ST_CBR_CAS;
                end
            ST_CBR_CAS:  nxt = ST_CBR_RAS;
            ST_CBR_RAS:  if (dly_done) nxt = ST_PRECHG;
            ST_ROR_ADDR: nxt = ST_ROR_RAS;
            ST_ROR_RAS:  if (dly_done) nxt = ST_PRECHG;
            ST_PRECHG:
                if (dly_done) begin
                    if (burst_left > BW'(1)) begin
                        burst_nxt = burst_left - 1'b1;
                        nxt       = ST_CBR_CAS;
                    end else if (burst_left == BW'(1)) begin
                        burst_nxt = '0;
                        nxt       = enter_pend ? ST_SR_CAS : ST_IDLE;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            ST_SR_CAS:  nxt = ST_SR_HOLD;
            ST_SR_HOLD: if (dly_done && exit_seen) nxt = ST_SR_RECOVER;
            ST_SR_RECOVER:
                if (dly_done) begin
                    if (mode == MODE_BURST) begin
                        burst_nxt = BURST_LEN;
                        nxt       = ST_CBR_CAS;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            ST_CBR_RAS, ST_ROR_RAS: dly_ld = DW'(RAS_CYC - 1);
            ST_PRECHG:              dly_ld = DW'(PRE_CYC - 1);
            ST_SR_HOLD:             dly_ld = DW'(SR_MIN_CYC - 1);
            ST_SR_RECOVER:          dly_ld = DW'(SR_PRE_CYC - 1);
            default:                dly_ld = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            dly        <= '0;
            burst_left <= '0;
        end else begin
            st         <= nxt;
            burst_left <= burst_nxt;
            if (nxt != st)      dly <= dly_ld;
            else if (!dly_done) dly <= dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enter_pend <= 1'b0;
            exit_seen  <= 1'b0;
        end else begin
            if (st == ST_SR_CAS)          enter_pend <= 1'b0;
            else if (sr_enter_i && !in_sr) enter_pend <= 1'b1;
            if (st != ST_SR_HOLD)          exit_seen  <= 1'b0;
            else if (sr_exit_i)            exit_seen  <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ras_n_o   = 1'b1;
        cas_n_o   = 1'b1;
        addr_oe_o = 1'b0;
        unique case (st)
            ST_CBR_CAS, ST_SR_CAS:  cas_n_o = 1'b0;
            ST_CBR_RAS, ST_SR_HOLD: begin ras_n_o = 1'b0; cas_n_o = 1'b0; end
            ST_ROR_ADDR:            addr_oe_o = 1'b1;
            ST_ROR_RAS:             begin ras_n_o = 1'b0; addr_oe_o = 1'b1; end
            default: ;
        endcase
    end

    assign bus_req_o = (st != ST_IDLE);
    assign busy_o    = bus_req_o || (owed != '0) || enter_pend;

    // R3 / R8: whenever both strobes are low after RAS falls, CAS led
    p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
    p_ror_cas_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && addr_oe_o) |-> cas_n_o);
    p_ror_addr_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && addr_oe_o) |-> ($past(addr_oe_o) && $stable(addr_o)));
    p_strobe_under_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !cas_n_o) |-> bus_req_o);
    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |=> (ras_n_o && cas_n_o));
endmodule

// File: tb/dram_rfsh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_sched_tb_top;
    localparam int ROW_W = 11, INTERVAL = 16, RAS_C = 4, PRE_C = 3;
    localparam int SR_MIN = 50, SR_PRE = 6, MAXO = 8;
    localparam int ROWS = 1 << ROW_W;
    localparam int K_CBR = 0, K_ROR = 1, K_SR = 2;

    typedef struct { int kind; int row; int len; } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic sr_enter = 1'b0, sr_exit = 1'b0, gnt = 1'b0;
    logic req, busy, ras_n, cas_n, addr_oe, ovf;
    logic [ROW_W-1:0] addr;

    int n_chk = 0, n_fail = 0;
    item_t exp_q[$];
    bit block = 1'b0;
    int gnt_delay = 3;

    always #2.5 clk = ~clk;

    dram_rfsh_sched #(.ROW_W(ROW_W), .INTERVAL_CYC(INTERVAL), .RAS_CYC(RAS_C),
        .PRE_CYC(PRE_C), .SR_MIN_CYC(SR_MIN), .SR_PRE_CYC(SR_PRE), .MAX_OWED(MAXO)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
        .bus_gnt_i(gnt), .bus_req_o(req), .busy_o(busy), .ras_n_o(ras_n), .cas_n_o(cas_n),
        .addr_o(addr), .addr_oe_o(addr_oe), .overflow_o(ovf));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int r, input int l);
        item_t it;
        it.kind = k; it.row = r; it.len = l;
        exp_q.push_back(it);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // grant responder
    int gcnt = 0;
    initial forever begin
        @(negedge clk);
        if (!req || block) begin gnt = 1'b0; gcnt = 0; end
        else if (gcnt >= gnt_delay) gnt = 1'b1;
        else gcnt++;
    end

    // monitor
    bit pr = 1, pc = 1, po = 0, is_cbr = 0, after_sr = 0, have_rise = 0;
    int low = 0, hi = 0, frow = 0, kind = 0, need = 0;
    item_t e;
    initial forever begin
        @(negedge clk);
        if (!rst_n) begin
            pr = 1; pc = 1; po = 0; have_rise = 0;
        end else begin
            if ((!ras_n || !cas_n) && !gnt) chk(0, "R2 strobe without grant", 0, 1);
            if (have_rise && (!ras_n || !cas_n)) begin
                need = after_sr ? SR_PRE : PRE_C;
                chk(hi >= need, after_sr ? "R9 exit precharge" : "R5 precharge", hi, need);
                have_rise = 0;
            end
            if (have_rise) hi++;
            if (pr && !ras_n) begin
                low = 1; frow = int'(addr); is_cbr = !cas_n;
                if (is_cbr) chk(!pc, "R3 CAS leads RAS", int'(pc), 0);
                else        chk(po && addr_oe, "R4 address before RAS", int'(po), 1);
            end else if (!ras_n) begin
                low++;
                if (!is_cbr && !cas_n) chk(0, "R4 CAS low in RAS-only", 0, 1);
            end
            if (!pr && ras_n) begin
                kind = !is_cbr ? K_ROR : ((low > RAS_C) ? K_SR : K_CBR);
                after_sr = (kind == K_SR); have_rise = 1; hi = 1;
                if (exp_q.size() == 0) chk(0, "R2 unexpected refresh", kind, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(kind == e.kind, "R10 sequence kind", kind, e.kind);
                    if (e.kind == K_ROR) chk(frow == e.row, "R6 row address", frow, e.row);
                    if (e.len < 0) chk(low >= SR_MIN, "R8 self-refresh hold", low, SR_MIN);
                    else chk(low == e.len, e.kind == K_SR ? "R8 early exit hold" : "R3 RAS width", low, e.len);
                end
            end
            pr = ras_n; pc = cas_n; po = addr_oe;
        end
    end

    task automatic wait_empty;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_enter;
        @(negedge clk); sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    endtask

    task automatic pulse_exit;
        @(negedge clk); sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin : driver
        bit stay_high;
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && !req && !busy && !addr_oe && !ovf, "R1 reset state", 0, 1);
        push(K_CBR, -1, RAS_C); push(K_CBR, -1, RAS_C);
        rst_n = 1'b1;
        repeat (INTERVAL - 2) @(negedge clk);
        chk(!req, "R2 no request before interval", int'(req), 0);
        chk(ras_n && cas_n && !ovf, "R1 idle after reset", 0, 1);
        repeat (5) @(negedge clk);
        chk(req, "R2 request after interval", int'(req), 1);
        chk(busy, "R2 busy while owed", int'(busy), 1);
        wait_empty();
        block = 1'b1;
        // R7: hold the bus away
        repeat (6 * INTERVAL) @(negedge clk);
        chk(!ovf, "R7 no overflow below limit", int'(ovf), 0);
        repeat (6 * INTERVAL) @(negedge clk);
        chk(ovf, "R7 overflow after limit", int'(ovf), 1);
        // R4 / R6: RAS-only with wrap
        mode = 2'd1;
        for (int i = 0; i < ROWS + 2; i++) push(K_ROR, i % ROWS, RAS_C);
        gnt_delay = 1;
        block = 1'b0;
        wait_empty();
        block = 1'b1;
        // R8: self refresh with early exit pulse
        mode = 2'd0;
        pulse_enter();
        push(K_SR, -1, SR_MIN);
        block = 1'b0;
        while (!(!ras_n && !cas_n)) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_exit();
        wait_empty();
        block = 1'b1;
        repeat (SR_PRE + 4) @(negedge clk);
        chk(!req, "R11 no request after self refresh", int'(req), 0);
        // R9: exit pulse outside self refresh
        pulse_exit();
        stay_high = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n) stay_high = 1'b0;
        end
        chk(stay_high, "R9 stray exit ignored", int'(stay_high), 1);
        // R10: burst around self refresh
        mode = 2'd2;
        gnt_delay = 0;
        pulse_enter();
        for (int i = 0; i < ROWS; i++) push(K_CBR, -1, RAS_C);
        push(K_SR, -1, -1);
        block = 1'b0;
        while (exp_q.size() > 1) begin
            @(negedge clk);
            if (exp_q.size() > 1 && !req) chk(0, "R10 request held in burst", 0, 1);
        end
        while (ras_n) @(negedge clk);
        repeat (SR_MIN + 10) @(negedge clk);
        for (int i = 0; i < ROWS; i++) push(K_CBR, -1, RAS_C);
        pulse_exit();
        wait_empty();
        block = 1'b1;
        repeat (PRE_C + 5) @(negedge clk);
        chk(!req, "R11 no request after burst", int'(req), 0);
        chk(ovf, "R7 overflow sticky", int'(ovf), 1);
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule